// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Canceling Delay Slot

This block sits in the decode stage of a five-stage in-order pipeline. It takes a decoded branch opcode, the value of the register under test, the branch's own PC, a sign-extended word offset and a static prediction bit. It decides the zero test in decode and forms both candidate PCs with a private adder, so the execute-stage ALU is never involved. A taken branch therefore costs one cycle, and that cycle is the delay slot.

Exactly one instruction follows each branch in its delay slot. For a canceling branch, the block compares the actual outcome with the prediction bit carried by the branch. When the two disagree, the slot instruction is nullified: its valid bit is cleared on the way into the decode-to-execute register, so it can cause no register or memory write. A non-canceling branch always lets its slot instruction complete.

Top module: `early_branch_unit`

## Requirements
- R1: Opcode code 1 (branch-if-zero) is taken exactly when the tested register equals zero.
- R2: Opcode code 2 (branch-if-nonzero) is taken exactly when the tested register differs from zero. Codes 0 and 3 are not branches and never resolve or redirect.
- R3: When a branch is taken, `next_pc` equals the branch PC plus 4 plus the offset shifted left by 2, truncated to the PC width.
- R4: When a branch is resolved not taken, `next_pc` equals the branch PC plus 8, which is the instruction after the delay slot.
- R5: `redirect` and `br_resolved` are combinational in the cycle where the branch is in decode. `redirect` is high only for a taken branch, and both outputs are low when `dec_valid` is low.
- R6: A canceling branch (`dec_cancel`=1) whose outcome matches `dec_pred_taken` leaves its slot instruction valid.
- R7: A canceling branch whose outcome differs from `dec_pred_taken` raises `slot_annul` while its slot instruction is in decode. That instruction then reaches `dx_valid` as 0 one cycle later.
- R8: A non-canceling branch never annuls its slot instruction, whatever the outcome.
- R9: The slot is the next cycle with `dec_valid` high. Cycles without a valid instruction between the branch and the slot keep the pending annul decision.
- R10: An annulled slot instruction has no effect even if it decodes as a branch. It does not resolve, does not redirect and does not open a new delay slot.
- R11: After reset, `dx_valid` is 0 and no annul is pending.
- R12: `dx_valid` equals `dec_valid` and not `slot_annul`, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A valid instruction is in decode |
| dec_op | input | 2 | Branch opcode: 0 none, 1 branch-if-zero, 2 branch-if-nonzero, 3 none |
| dec_cancel | input | 1 | Branch is of the canceling kind |
| dec_pred_taken | input | 1 | Static prediction carried by the branch |
| rs_value | input | XLEN | Value of the tested register |
| dec_pc | input | AW | PC of the instruction in decode |
| dec_offset | input | AW | Sign-extended word offset |
| redirect | output | 1 | Fetch must load `next_pc` (branch taken) |
| br_resolved | output | 1 | A branch was resolved this cycle; `next_pc` is meaningful |
| next_pc | output | AW | Target or fall-through PC |
| slot_annul | output | 1 | The instruction in decode is a nullified delay slot |
| dx_valid | output | 1 | Valid bit of the decode-to-execute register |

## Verification
The bench builds the block with a 12-bit PC and an 8-bit tested register. The narrow register makes zero values common, so random traffic covers both outcomes of both opcodes. The short PC makes target wrap-around past the top of the address space and negative offsets below address zero easy to reach. Directed runs cover bubbles before the slot and a branch placed in an annulled slot.

// File: rtl/ebu_pkg.sv
// Package: shared opcode encoding for the decode-stage branch resolver.
// Assumes the decoder presents these 2-bit codes on dec_op.
package ebu_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_BEQZ = 2'd1,
        OP_BNEZ = 2'd2,
        OP_RSVD = 2'd3
    } br_op_e;
endpackage

// File: rtl/ebu_cond.sv
// Module: zero-test condition evaluation.
// Decides whether the decoded opcode is a branch and whether it is taken.
// Assumes rs_value is already forwarded to decode.
module ebu_cond #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] value,
    output logic            is_branch,
    output logic            cond_true
);
    import ebu_pkg::*;

    logic is_zero;

    // Reduce the tested register to a zero flag and pick the polarity.
    always_comb begin
        is_zero = (value == '0);
        unique case (br_op_e'(op))
            OP_BEQZ: begin is_branch = 1'b1; cond_true = is_zero;  end
            OP_BNEZ: begin is_branch = 1'b1; cond_true = !is_zero; end
            default: begin is_branch = 1'b0; cond_true = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/ebu_target.sv
// Module: dedicated PC adder for decode-stage resolution.
// Forms the taken target (pc + 4 + offset<<SHIFT) and the fall-through
// pc + 8, both wrapping modulo 2^AW. Assumes 4-byte instructions.
module ebu_target #(
    parameter int AW    = 32,
    parameter int SHIFT = 2
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] taken_pc,
    output logic [AW-1:0] fall_pc
);
    localparam int            INSTR_BYTES = 1 << SHIFT;
    localparam logic [AW-1:0] STEP1 = AW'(INSTR_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * INSTR_BYTES);

    logic [AW-1:0] off_scaled;

    generate
        if (SHIFT > 0) begin : g_shift
            assign off_scaled = {offset[AW-1-SHIFT:0], {SHIFT{1'b0}}};
        end else begin : g_noshift
            assign off_scaled = offset;
        end
    endgenerate

    // Add the scaled offset to the PC of the delay slot, and skip the slot for fall-through.
    always_comb begin
        taken_pc = pc + STEP1 + off_scaled;
        fall_pc  = pc + STEP2;
    end
endmodule

// File: rtl/ebu_slot.sv
// Module: delay-slot tracker and decode-to-execute valid bit.
// Remembers that the next valid decode instruction is a delay slot and
// whether it must be nullified. Assumes no stall freezes decode other
// than dec_valid being low.
module ebu_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic branch_ok,
    input  logic mispredict,
    output logic slot_annul,
    output logic dx_valid
);
    logic slot_pend_q;
    logic annul_pend_q;

    // The instruction now in decode is a nullified slot.
    always_comb slot_annul = dec_valid && slot_pend_q && annul_pend_q;

    // Track the pending slot and its annul decision across bubbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_pend_q  <= 1'b0;
            annul_pend_q <= 1'b0;
        end else if (dec_valid) begin
            slot_pend_q  <= branch_ok;
            annul_pend_q <= mispredict;
        end
    end

    // Load the decode-to-execute valid bit, cleared for a nullified slot.
    always_ff @(posedge clk) begin
        if (!rst_n) dx_valid <= 1'b0;
        else        dx_valid <= dec_valid && !slot_annul;
    end

    // R7
    annul_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_annul |=> !dx_valid);

    // R12
    dx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !slot_annul) |=> dx_valid);

    // R8
    noncancel_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && branch_ok && !mispredict) |=> !slot_annul);
endmodule

// File: rtl/early_branch_unit.sv
// Module: decode-stage branch resolver with a canceling delay slot.
// Resolves zero-test branches in decode, selects the next PC and nullifies
// the single delay-slot instruction on a canceling-branch mispredict.
// Assumes operands are forwarded to decode and no branch sits in a live slot.
module early_branch_unit #(
    parameter int XLEN  = 32,
    parameter int AW    = 32,
    parameter int SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [1:0]      dec_op,
    input  logic            dec_cancel,
    input  logic            dec_pred_taken,
    input  logic [XLEN-1:0] rs_value,
    input  logic [AW-1:0]   dec_pc,
    input  logic [AW-1:0]   dec_offset,
    output logic            redirect,
    output logic            br_resolved,
    output logic [AW-1:0]   next_pc,
    output logic            slot_annul,
    output logic            dx_valid
);
    logic          is_branch;
    logic          cond_true;
    logic [AW-1:0] taken_pc;
    logic [AW-1:0] fall_pc;
    logic          branch_ok;
    logic          taken;
    logic          mispredict;

    ebu_cond #(.XLEN(XLEN)) u_cond (
        .op        (dec_op),
        .value     (rs_value),
        .is_branch (is_branch),
        .cond_true (cond_true)
    );

    ebu_target #(.AW(AW), .SHIFT(SHIFT)) u_target (
        .pc       (dec_pc),
        .offset   (dec_offset),
        .taken_pc (taken_pc),
        .fall_pc  (fall_pc)
    );

    ebu_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .branch_ok  (branch_ok),
        .mispredict (mispredict),
        .slot_annul (slot_annul),
        .dx_valid   (dx_valid)
    );

    // Qualify the branch, pick the next PC and flag a canceling mispredict.
    always_comb begin
        branch_ok   = dec_valid && is_branch && !slot_annul;
        taken       = branch_ok && cond_true;
        mispredict  = branch_ok && dec_cancel && (cond_true != dec_pred_taken);
        redirect    = taken;
        br_resolved = branch_ok;
        next_pc     = taken ? taken_pc : fall_pc;
    end

    // R5
    redirect_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (br_resolved && dec_valid));

    // R10
    annulled_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_annul |-> (!br_resolved && !redirect));

    // R1
    beqz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolved && dec_op == 2'd1 && rs_value == '0) |-> redirect);

    // R2
    bnez_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolved && dec_op == 2'd2 && rs_value == '0) |-> !redirect);
endmodule

// File: tb/sim_early_branch_unit.sv
module sim_early_branch_unit;
    localparam int XLEN = 8;
    localparam int AW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dec_valid = 1'b0;
    logic [1:0]      dec_op = 2'd0;
    logic            dec_cancel = 1'b0;
    logic            dec_pred_taken = 1'b0;
    logic [XLEN-1:0] rs_value = '0;
    logic [AW-1:0]   dec_pc = '0;
    logic [AW-1:0]   dec_offset = '0;
    logic            redirect, br_resolved, slot_annul, dx_valid;
    logic [AW-1:0]   next_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit m_slot = 0, m_annul = 0;

    always #10 clk = ~clk;

    early_branch_unit #(.XLEN(XLEN), .AW(AW), .SHIFT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
        .dec_cancel(dec_cancel), .dec_pred_taken(dec_pred_taken),
        .rs_value(rs_value), .dec_pc(dec_pc), .dec_offset(dec_offset),
        .redirect(redirect), .br_resolved(br_resolved), .next_pc(next_pc),
        .slot_annul(slot_annul), .dx_valid(dx_valid)
    );

    function automatic bit f_cond(logic [1:0] op, logic [XLEN-1:0] v);
        if (op == 2'd1) return v == '0;
        if (op == 2'd2) return v != '0;
        return 1'b0;
    endfunction

    function automatic logic [AW-1:0] f_target(logic [AW-1:0] pc, logic [AW-1:0] off);
        return pc + AW'(4) + (off << 2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one decode cycle (called just after a falling edge), check it, advance.
    task automatic step(bit v, logic [1:0] op, bit cn, bit pr,
                        logic [XLEN-1:0] rs, logic [AW-1:0] pc, logic [AW-1:0] off);
        bit an, isbr, ok, tk, exp_dx;
        logic [AW-1:0] np;
        dec_valid = v; dec_op = op; dec_cancel = cn; dec_pred_taken = pr;
        rs_value = rs; dec_pc = pc; dec_offset = off;
        #5;
        an   = v && m_slot && m_annul;
        isbr = (op == 2'd1) || (op == 2'd2);
        ok   = v && isbr && !an;
        tk   = ok && f_cond(op, rs);
        np   = tk ? f_target(pc, off) : pc + AW'(8);
        check(slot_annul == an, an ? "R7 slot_annul" : "R6/R8 slot_annul", slot_annul, an);
        check(br_resolved == ok, an ? "R10 br_resolved" : "R5 br_resolved", br_resolved, ok);
        check(redirect == tk, op == 2'd2 ? "R2 redirect" : "R1 redirect", redirect, tk);
        if (ok) check(next_pc == np, tk ? "R3 next_pc" : "R4 next_pc", next_pc, np);
        exp_dx = v && !an;
        if (v) begin
            m_slot  = ok;
            m_annul = ok && cn && (f_cond(op, rs) != pr);
        end
        @(posedge clk); #1;
        check(dx_valid == exp_dx, an ? "R7 dx_valid" : "R12 dx_valid", dx_valid, exp_dx);
        @(negedge clk);
    endtask

    task automatic nop_slot(logic [AW-1:0] pc);
        step(1, 2'd0, 0, 0, 8'h11, pc, '0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(dx_valid == 1'b0, "R11 dx_valid", dx_valid, 0);
        check(slot_annul == 1'b0, "R11 slot_annul", slot_annul, 0);
        rst_n = 1'b1;
        // R1/R6: beqz taken, canceling, predicted taken -> slot kept
        step(1, 2'd1, 1, 1, 8'h00, 12'h100, 12'h010);
        nop_slot(12'h104);
        // R7: beqz taken, canceling, predicted not taken -> slot annulled
        step(1, 2'd1, 1, 0, 8'h00, 12'h200, 12'h004);
        nop_slot(12'h204);
        // R2/R4/R7: bnez not taken, canceling, predicted taken -> annul
        step(1, 2'd2, 1, 1, 8'h00, 12'h300, 12'h020);
        nop_slot(12'h304);
        // R8: non-canceling mispredict keeps slot
        step(1, 2'd2, 0, 0, 8'h05, 12'h400, 12'hFFE);
        nop_slot(12'h404);
        // R9: bubbles before the slot keep the annul decision
        step(1, 2'd1, 1, 1, 8'h07, 12'h500, 12'h003);
        step(0, 2'd1, 0, 0, 8'h00, 12'h000, 12'h000);
        step(0, 2'd0, 0, 0, 8'h00, 12'h000, 12'h000);
        nop_slot(12'h504);
        // R10: taken branch in an annulled slot is inert
        step(1, 2'd2, 1, 0, 8'h09, 12'h600, 12'h040);
        step(1, 2'd1, 1, 1, 8'h00, 12'h604, 12'h040);
        nop_slot(12'h608);
        // R3: target wraps past the top, and negative offset below zero
        step(1, 2'd1, 0, 1, 8'h00, 12'hFF8, 12'h005);
        nop_slot(12'hFFC);
        step(1, 2'd2, 0, 1, 8'h01, 12'h008, 12'hFF0);
        nop_slot(12'h00C);
        // R2: codes 0 and 3 never resolve
        step(1, 2'd3, 1, 1, 8'h00, 12'h700, 12'h001);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [XLEN-1:0] rv;
            rv = ($urandom % 3 == 0) ? '0 : XLEN'($urandom);
            step(($urandom % 5) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
                 rv, AW'($urandom), AW'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule